// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block keeps the floating-point status word and the floating-point control word for a scalar FP pipeline. It does no arithmetic. When an arithmetic unit finishes an operation, it presents one strobe together with:

- the class of the result,
- the sign of the result,
- the exception flags raised by that operation.

On that strobe the block does three things in one cycle:

- It rebuilds the condition-code nibble.
- It replaces the per-operation exception byte.
- It folds the new exceptions into the sticky accrued byte.

A trap request is asserted whenever an exception that is present in the status word is also enabled in the control word. Software loads either register through a simple write port, and each register keeps only its writable bits.

Status word layout:

| Bits | Contents |
|------|----------|
| 27:24 | Condition codes. From bit 27 down: negative, zero, infinity, not-a-number. |
| 15:8 | Per-operation exceptions. From bit 15 down: branch-on-unordered, signalling NaN, operand error, overflow, underflow, divide-by-zero, inexact result, inexact decimal input. |
| 7:3 | Accrued exceptions. From bit 7 down: invalid, overflow, underflow, divide-by-zero, inexact. |

In the control word, bits 15:8 are the trap enables. They use the same bit order as the exception byte.

Top module: `fp_status_unit`

## Requirements
- R1: After reset the status word, the control word and the trap output are all zero.
- R2: One cycle after a result strobe, status bits 27:24 are rebuilt from the result alone. Bit 27 equals the sign. Class code 0 or 1 (NaN) sets bit 24. Class 2 (zero) sets bit 26. Class 4 (infinity) sets bit 25. Class 3 (number) and the unused codes 5 to 7 set none of bits 26:24.
- R3: A result of class 0 (signalling NaN) also sets exception bit 14, even when the operation did not flag it. Class 1 sets only the NaN condition bit.
- R4: On a result strobe, the exception byte (bits 15:8) is replaced by the operation's flags, so earlier exceptions do not remain. Status bits 31:28, 23:16 and 2:0 are left unchanged.
- R5: Accrued bit 7 is set when any of exception bits 15, 14 or 13 is set after the update. Accrued bit 6 is set when bit 12 is set. Accrued bit 4 is set when bit 10 is set.
- R6: Accrued bit 5 is set only when exception bits 11 and 9 are both set. Accrued bit 3 is set when any of bits 12, 9 or 8 is set.
- R7: A result strobe only ORs bits into the accrued byte (bits 7:3); a result never clears one.
- R8: The trap output is high in exactly those cycles in which the AND of status bits 15:8 and control bits 15:8 is nonzero.
- R9: A write to the control word (select 0) stores only bits 15:4, and all other bits read as zero. A write to the status word (select 1) stores only bits 27:3. Either write is visible one cycle later.
- R10: If a status write and a result strobe arrive in the same cycle, the write is stored and the result is dropped. If a control write arrives with a result, both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result strobe from the arithmetic unit |
| res_class | input | 3 | Result class code (0 sNaN, 1 qNaN, 2 zero, 3 number, 4 infinity) |
| res_sign | input | 1 | Result sign |
| res_exc | input | 8 | Per-operation exception flags, same order as status bits 15:8 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 status word |
| wr_data | input | 32 | Write data |
| status_o | output | 32 | Status word |
| control_o | output | 32 | Control word |
| trap_o | output | 1 | Enabled-exception trap request |

## Verification
The clocked properties assume the following about the inputs:

- Strobes are sampled only on clock edges.
- A result that collides with a status write is discarded. For that reason, the result-side properties are qualified by the absence of a status write.

The stimulus keeps to these assumptions. It drives every input at the falling edge. It reloads the status word with a known pattern before each swept result, so that every class, sign and exception byte starts from a defined accrued state. Collisions between writes and results appear only in the dedicated priority tests.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;

    localparam int REG_W   = 32;
    localparam int CC_LSB  = 24;
    localparam int CC_W    = 4;
    localparam int EXC_LSB = 8;
    localparam int EXC_W   = 8;
    localparam int ACC_LSB = 3;
    localparam int ACC_W   = 5;
    localparam int EN_LSB  = 8;

    // condition-code nibble bit indices
    localparam int CC_NAN = 0;
    localparam int CC_INF = 1;
    localparam int CC_ZRO = 2;
    localparam int CC_NEG = 3;

    // exception byte bit indices
    localparam int EX_INEXD = 0;
    localparam int EX_INEXR = 1;
    localparam int EX_DZ    = 2;
    localparam int EX_UNFL  = 3;
    localparam int EX_OVFL  = 4;
    localparam int EX_OPERR = 5;
    localparam int EX_SNAN  = 6;
    localparam int EX_BSUN  = 7;

    // accrued byte bit indices
    localparam int AC_INEX = 0;
    localparam int AC_DZ   = 1;
    localparam int AC_UNFL = 2;
    localparam int AC_OVFL = 3;
    localparam int AC_INV  = 4;

    typedef enum logic [2:0] {
        CLS_SNAN = 3'd0,
        CLS_QNAN = 3'd1,
        CLS_ZERO = 3'd2,
        CLS_NUM  = 3'd3,
        CLS_INF  = 3'd4
    } fp_class_e;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] control;
    } fpsu_state_t;

endpackage

// File: rtl/fpsu_cc_encode.sv
module fpsu_cc_encode
    import fpsu_pkg::*;
(
    input  logic [2:0]      cls,
    input  logic            sign,
    output logic [CC_W-1:0] cc,
    output logic            snan_hit
);

    always_comb begin
        cc         = '0;
        snan_hit   = 1'b0;
        cc[CC_NEG] = sign;
        case (cls)
            CLS_SNAN: begin
                cc[CC_NAN] = 1'b1;
                snan_hit   = 1'b1;
            end
            CLS_QNAN: cc[CC_NAN] = 1'b1;
            CLS_ZERO: cc[CC_ZRO] = 1'b1;
            CLS_INF:  cc[CC_INF] = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/fpsu_accrue.sv
module fpsu_accrue
    import fpsu_pkg::*;
(
    input  logic [EXC_W-1:0] exc,
    output logic [ACC_W-1:0] acc
);

    always_comb begin
        acc          = '0;
        acc[AC_INV]  = exc[EX_BSUN] | exc[EX_SNAN] | exc[EX_OPERR];
        acc[AC_OVFL] = exc[EX_OVFL];
        acc[AC_UNFL] = exc[EX_UNFL] & exc[EX_INEXR];
        acc[AC_DZ]   = exc[EX_DZ];
        acc[AC_INEX] = exc[EX_INEXD] | exc[EX_INEXR] | exc[EX_OVFL];
    end

endmodule

// File: rtl/fpsu_trap_detect.sv
module fpsu_trap_detect #(
    parameter int N = 8
) (
    input  logic [N-1:0] pending,
    input  logic [N-1:0] enable,
    output logic         trap
);

    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign hit[i] = pending[i] & enable[i];
    end

    assign trap = |hit;

endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
    import fpsu_pkg::*;
#(
    parameter logic [REG_W-1:0] CTRL_MASK = 32'h0000_FFF0,
    parameter logic [REG_W-1:0] STAT_MASK = 32'h0FFF_FFF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [2:0]       res_class,
    input  logic             res_sign,
    input  logic [EXC_W-1:0] res_exc,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] control_o,
    output logic             trap_o
);

    fpsu_state_t st_d, st_q;

    logic [CC_W-1:0]  cc_new;
    logic             snan_hit;
    logic [EXC_W-1:0] exc_new;
    logic [ACC_W-1:0] acc_new;
    logic             stat_wr;
    logic             ctrl_wr;

    assign stat_wr = wr_en & wr_sel;
    assign ctrl_wr = wr_en & ~wr_sel;

    fpsu_cc_encode u_cc (
        .cls      (res_class),
        .sign     (res_sign),
        .cc       (cc_new),
        .snan_hit (snan_hit)
    );

    always_comb begin
        exc_new          = res_exc;
        exc_new[EX_SNAN] = res_exc[EX_SNAN] | snan_hit;
    end

    fpsu_accrue u_acc (
        .exc (exc_new),
        .acc (acc_new)
    );

    always_comb begin
        st_d = st_q;
        if (res_valid) begin
            st_d.status[CC_LSB +: CC_W]   = cc_new;
            st_d.status[EXC_LSB +: EXC_W] = exc_new;
            st_d.status[ACC_LSB +: ACC_W] = st_q.status[ACC_LSB +: ACC_W] | acc_new;
        end
        if (ctrl_wr) begin
            st_d.control = wr_data & CTRL_MASK;
        end
        if (stat_wr) begin
            st_d.status = wr_data & STAT_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fpsu_trap_detect #(.N(EXC_W)) u_trap (
        .pending (st_q.status[EXC_LSB +: EXC_W]),
        .enable  (st_q.control[EN_LSB +: EXC_W]),
        .trap    (trap_o)
    );

    assign status_o  = st_q.status;
    assign control_o = st_q.control;

    // R2: after a result the class bits are at most one-hot and N follows the sign
    p_cc_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !stat_wr) |=>
            ($onehot0(status_o[CC_LSB +: 3]) &&
             status_o[CC_LSB + CC_NEG] == $past(res_sign)));

    // R4: the exception byte holds the operation flags (SNAN may be added)
    p_exc_replace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !stat_wr) |=>
            ((status_o[EXC_LSB +: EXC_W] | 8'h40) == ($past(res_exc) | 8'h40)));

    // R7: accrued bits are never cleared by a result
    p_acc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !stat_wr) |=>
            ((status_o[ACC_LSB +: ACC_W] & $past(status_o[ACC_LSB +: ACC_W])) ==
             $past(status_o[ACC_LSB +: ACC_W])));

    // R6: accrued underflow cannot appear without underflow and inexact together
    p_unfl_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !stat_wr && !status_o[ACC_LSB + AC_UNFL] &&
         !(res_exc[EX_UNFL] && res_exc[EX_INEXR])) |=>
            !status_o[ACC_LSB + AC_UNFL]);

    // R9: control writes keep only the writable field
    p_ctrl_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (control_o == ($past(wr_data) & CTRL_MASK)));

    // R10: a status write wins over a simultaneous result
    p_stat_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (status_o == ($past(wr_data) & STAT_MASK)));

endmodule

// File: tb/fp_status_unit_test.sv
`timescale 1ns/1ps
module fp_status_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [2:0]  res_class;
    logic        res_sign;
    logic [7:0]  res_exc;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic [31:0] status_o;
    logic [31:0] control_o;
    logic        trap_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_stat = 32'h0;
    logic [31:0] m_ctrl = 32'h0;

    always #4 clk = ~clk;

    fp_status_unit uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_class(res_class),
        .res_sign(res_sign), .res_exc(res_exc), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status_o(status_o), .control_o(control_o), .trap_o(trap_o)
    );

    function automatic logic [31:0] model_result(input logic [31:0] old, input logic [2:0] c,
                                                 input logic s, input logic [7:0] e);
        logic [31:0] r;
        logic [7:0]  x;
        x = e;
        if (c == 3'd0) x[6] = 1'b1;
        r = old;
        r[27:24] = 4'b0;
        r[27] = s;
        if (c == 3'd0 || c == 3'd1) r[24] = 1'b1;
        if (c == 3'd2) r[26] = 1'b1;
        if (c == 3'd4) r[25] = 1'b1;
        r[15:8] = x;
        if ((x & 8'hE0) != 0) r[7] = 1'b1;
        if (x[4]) r[6] = 1'b1;
        if (x[3] && x[1]) r[5] = 1'b1;
        if (x[2]) r[4] = 1'b1;
        if (x[0] || x[1] || x[4]) r[3] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic [2:0] c, input logic s, input logic [7:0] e,
                        input logic we, input logic ws, input logic [31:0] wd);
        @(negedge clk);
        res_valid = rv; res_class = c; res_sign = s; res_exc = e;
        wr_en = we; wr_sel = ws; wr_data = wd;
        @(negedge clk);
        res_valid = 1'b0; wr_en = 1'b0;
        if (rv && !(we && ws)) m_stat = model_result(m_stat, c, s, e);
        if (we && !ws) m_ctrl = wd & 32'h0000_FFF0;
        if (we && ws)  m_stat = wd & 32'h0FFF_FFF8;
    endtask

    function automatic logic model_trap();
        return (m_stat[15:8] & m_ctrl[15:8]) != 8'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; res_valid = 1'b0; res_class = 3'd0; res_sign = 1'b0;
        res_exc = 8'h0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status reset", status_o, 32'h0);
        check("R1 control reset", control_o, 32'h0);
        check("R1 trap reset", {31'b0, trap_o}, 32'h0);

        // R9 masks
        step(1'b0, 3'd0, 1'b0, 8'h0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        check("R9 control mask", control_o, 32'h0000_FFF0);
        step(1'b0, 3'd0, 1'b0, 8'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        check("R9 status mask", status_o, 32'h0FFF_FFF8);
        check("R8 trap all enabled", {31'b0, trap_o}, {31'b0, model_trap()});

        // exhaustive sweep of class, sign and exception byte
        step(1'b0, 3'd0, 1'b0, 8'h0, 1'b1, 1'b0, 32'h0);
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int e = 0; e < 256; e++) begin
                    step(1'b0, 3'd0, 1'b0, 8'h0, 1'b1, 1'b1, 32'h00A5_FF00);
                    step(1'b1, 3'(c), 1'(s), 8'(e), 1'b0, 1'b0, 32'h0);
                    check("R2 R3 R4 R5 R6 result update", status_o, m_stat);
                end
            end
        end

        // R7 accumulation across results
        step(1'b0, 3'd0, 1'b0, 8'h0, 1'b1, 1'b1, 32'h0);
        step(1'b1, 3'd3, 1'b0, 8'h01, 1'b0, 1'b0, 32'h0);
        step(1'b1, 3'd3, 1'b1, 8'h04, 1'b0, 1'b0, 32'h0);
        check("R7 accrued kept", status_o, m_stat);
        step(1'b1, 3'd2, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0);
        check("R7 clean result keeps accrued", status_o, m_stat);
        step(1'b1, 3'd0, 1'b0, 8'h18, 1'b0, 1'b0, 32'h0);
        check("R7 R6 snan plus unfl without inexact", status_o, m_stat);

        // R8 trap matrix
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                step(1'b0, 3'd0, 1'b0, 8'h0, 1'b1, 1'b0, 32'(1) << (8 + i));
                step(1'b1, 3'd3, 1'b0, 8'(1) << j, 1'b0, 1'b0, 32'h0);
                check("R8 trap", {31'b0, trap_o}, {31'b0, model_trap()});
                check("R8 trap expected value", {31'b0, model_trap()}, {31'b0, (i == j)});
            end
        end

        // R10 priorities
        step(1'b0, 3'd0, 1'b0, 8'h0, 1'b1, 1'b0, 32'h0);
        step(1'b1, 3'd4, 1'b1, 8'hFF, 1'b1, 1'b1, 32'h1234_5678);
        check("R10 status write wins", status_o, 32'h0234_5678);
        step(1'b1, 3'd2, 1'b1, 8'h10, 1'b1, 1'b0, 32'h0000_1F0F);
        check("R10 control write with result", control_o, 32'h0000_1F00);
        check("R10 result applied with control write", status_o, m_stat);
        check("R10 R8 trap after both", {31'b0, trap_o}, {31'b0, model_trap()});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule